// File: doc/BRIEF.md
# NAND Flash Clock Gate and Chip-Enable Sequencer

This block sits beside a NAND flash controller and owns two things: the enable of the controller's clock gate and the active-low chip-enable line of the flash. It keeps a three-valued clock state (off, running, idle) and changes it in response to chip select and deselect requests and to power-down and power-up requests. A build-time parameter decides whether the idle state may ever be entered. If it may not, every request for idle is dropped and the clock keeps whatever state it already had.

The steps inside each request happen in a fixed order, one per clock edge. A select turns the clock on before it pulls chip-enable low. A deselect releases chip-enable and then asks for idle. A power-down saves the chip-enable level, forces chip-enable high and stops the clock. A power-up restarts the clock, raises a one-cycle pulse that tells the timing logic to reload, puts back the saved chip-enable level and then asks for idle.

Requests are single-cycle pulses. While a sequence is still running, `busy` is high and every new request is dropped. The block has no streaming data path, so no valid/ready interface applies and all pins are plain control and status.

Top module: `nand_cgcs`

## Requirements
- R1: After reset, clk_state is off, clk_gate_en is 0, chip_en_n is 1, and sel_err, timing_init and busy are all 0.
- R2: clk_state encodes off as 0, running as 1 and idle as 2. A request for a state takes effect at the edge that serves it.
- R3: clk_gate_en is 1 exactly when clk_state is running. It rises only when the state enters running and falls only when it leaves running.
- R4: When ALLOW_IDLE is 0, a request for idle changes nothing, so clk_state and clk_gate_en keep their values.
- R5: A select whose index is at most NUM_CHIPS sets clk_state to running at the edge that samples it. chip_en_n goes low one edge later, and busy is 1 in between.
- R6: A select whose index is greater than NUM_CHIPS leaves chip_en_n unchanged and pulses sel_err for one cycle. The clock is still set to running.
- R7: A deselect drives chip_en_n high at the edge that samples it. One edge later it requests idle.
- R8: A power-down request saves the current chip_en_n level, drives chip_en_n high and sets clk_state to off, all at the same edge.
- R9: A power-up request sets clk_state to running and pulses timing_init for one cycle. At the next edge chip_en_n takes the saved level, and at the edge after that idle is requested.
- R10: When requests arrive together, power-down wins over power-up, power-up over deselect, and deselect over select. Any request that arrives while busy is 1 is dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_req | input | 1 | Chip select request pulse |
| sel_idx | input | IDX_W | Index of the chip to select |
| desel_req | input | 1 | Chip deselect request pulse |
| pm_suspend_req | input | 1 | Power-down request pulse |
| pm_resume_req | input | 1 | Power-up request pulse |
| clk_gate_en | output | 1 | Enable for the controller clock gate |
| chip_en_n | output | 1 | Active-low flash chip enable |
| clk_state | output | 2 | Clock state (0 off, 1 running, 2 idle) |
| sel_err | output | 1 | One-cycle pulse when a select is rejected |
| timing_init | output | 1 | One-cycle pulse asking the timing logic to reload |
| busy | output | 1 | A multi-step sequence is in progress |

## Verification
If the sequencer phase is wrong, it shows at the ports within one or two cycles. chip_en_n can move on the wrong edge, busy can stay high, or idle can be requested when it should not be. If the saved chip-enable level is lost, nothing shows until the next power-up, when the restore step drives chip_en_n to the wrong level. A wrong clock state shows at once as a mismatch between clk_gate_en and clk_state. A second instance with idling forbidden makes any leak of an idle request show as a state change.

// File: rtl/nand_cgcs_pkg.sv
package nand_cgcs_pkg;

  typedef enum logic [1:0] {
    CS_OFF     = 2'd0,
    CS_RUNNING = 2'd1,
    CS_IDLE    = 2'd2
  } clk_state_t;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_SEL_CE   = 3'd1,
    PH_DES_IDLE = 3'd2,
    PH_RES_CE   = 3'd3,
    PH_RES_IDLE = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    CE_KEEP      = 3'd0,
    CE_LOW       = 3'd1,
    CE_HIGH      = 3'd2,
    CE_SAVE_HIGH = 3'd3,
    CE_RESTORE   = 3'd4
  } ce_op_t;

endpackage

// File: rtl/nand_cgcs_seq.sv
module nand_cgcs_seq
  import nand_cgcs_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_req,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             desel_req,
  input  logic             pm_suspend_req,
  input  logic             pm_resume_req,
  output logic             clk_req,
  output clk_state_t       clk_req_st,
  output ce_op_t           ce_op,
  output logic             sel_err,
  output logic             timing_init,
  output logic             busy
);

  localparam logic [IDX_W:0] MAX_IDX = (IDX_W+1)'(NUM_CHIPS);

  phase_t phase_q, phase_d;
  logic   err_d, tinit_d;
  logic   idx_ok;

  assign idx_ok = ({1'b0, sel_idx} <= MAX_IDX);
  assign busy   = (phase_q != PH_IDLE);

  always_comb begin
    clk_req    = 1'b0;
    clk_req_st = CS_OFF;
    ce_op      = CE_KEEP;
    phase_d    = phase_q;
    err_d      = 1'b0;
    tinit_d    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (pm_suspend_req) begin
          ce_op      = CE_SAVE_HIGH;
          clk_req    = 1'b1;
          clk_req_st = CS_OFF;
        end else if (pm_resume_req) begin
          clk_req    = 1'b1;
          clk_req_st = CS_RUNNING;
          tinit_d    = 1'b1;
          phase_d    = PH_RES_CE;
        end else if (desel_req) begin
          ce_op   = CE_HIGH;
          phase_d = PH_DES_IDLE;
        end else if (sel_req) begin
          clk_req    = 1'b1;
          clk_req_st = CS_RUNNING;
          if (idx_ok) phase_d = PH_SEL_CE;
          else        err_d   = 1'b1;
        end
      end
      PH_SEL_CE: begin
        ce_op   = CE_LOW;
        phase_d = PH_IDLE;
      end
      PH_DES_IDLE: begin
        clk_req    = 1'b1;
        clk_req_st = CS_IDLE;
        phase_d    = PH_IDLE;
      end
      PH_RES_CE: begin
        ce_op   = CE_RESTORE;
        phase_d = PH_RES_IDLE;
      end
      PH_RES_IDLE: begin
        clk_req    = 1'b1;
        clk_req_st = CS_IDLE;
        phase_d    = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      sel_err     <= 1'b0;
      timing_init <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      sel_err     <= err_d;
      timing_init <= tinit_d;
    end
  end

  // R10: a running sequence always returns to idle within two steps
  p_phase_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RES_CE) |=> (phase_q == PH_RES_IDLE));

  // R6: a rejected select never starts a sequence
  p_err_no_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/nand_cgcs_clkfsm.sv
module nand_cgcs_clkfsm
  import nand_cgcs_pkg::*;
#(
  parameter bit ALLOW_IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  clk_state_t req_st,
  output clk_state_t state,
  output logic       gate_en
);

  clk_state_t state_q;
  logic       gate_q;
  logic       veto;
  logic       accept;

  generate
    if (ALLOW_IDLE) begin : g_idle_ok
      assign veto = 1'b0;
    end else begin : g_idle_veto
      assign veto = (req_st == CS_IDLE);
    end
  endgenerate

  assign accept = req && !veto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_OFF;
      gate_q  <= 1'b0;
    end else if (accept) begin
      state_q <= req_st;
      if ((state_q == CS_RUNNING) && (req_st != CS_RUNNING)) gate_q <= 1'b0;
      else if ((state_q != CS_RUNNING) && (req_st == CS_RUNNING)) gate_q <= 1'b1;
    end
  end

  assign state   = state_q;
  assign gate_en = gate_q;

  // R3: gate rises only on entry to running
  p_gate_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> ($past(state_q) != CS_RUNNING) && (state_q == CS_RUNNING));

  // R3: gate falls only on exit from running
  p_gate_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> ($past(state_q) == CS_RUNNING) && (state_q != CS_RUNNING));

  // R4: idle is unreachable when idling is forbidden
  p_no_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_st == CS_IDLE && !ALLOW_IDLE) |=> $stable(state_q));

endmodule

// File: rtl/nand_cgcs_cereg.sv
module nand_cgcs_cereg
  import nand_cgcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ce_op_t op,
  output logic   ce_n
);

  logic ce_q;
  logic saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      saved_q <= 1'b1;
    end else begin
      case (op)
        CE_LOW:       ce_q <= 1'b0;
        CE_HIGH:      ce_q <= 1'b1;
        CE_SAVE_HIGH: begin
          saved_q <= ce_q;
          ce_q    <= 1'b1;
        end
        CE_RESTORE:   ce_q <= saved_q;
        default:      ce_q <= ce_q;
      endcase
    end
  end

  assign ce_n = ce_q;

  // R8: the level in force before power-down is the one saved
  p_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CE_SAVE_HIGH) |=> (saved_q == $past(ce_q)) && ce_q);

  // R9: restore brings back the saved level
  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CE_RESTORE) |=> (ce_q == $past(saved_q)));

endmodule

// File: rtl/nand_cgcs.sv
module nand_cgcs
  import nand_cgcs_pkg::*;
#(
  parameter int NUM_CHIPS  = 4,
  parameter int IDX_W      = 3,
  parameter bit ALLOW_IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_req,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             desel_req,
  input  logic             pm_suspend_req,
  input  logic             pm_resume_req,
  output logic             clk_gate_en,
  output logic             chip_en_n,
  output logic [1:0]       clk_state,
  output logic             sel_err,
  output logic             timing_init,
  output logic             busy
);

  logic       clk_req;
  clk_state_t clk_req_st;
  clk_state_t st;
  ce_op_t     ce_op;

  nand_cgcs_seq #(.NUM_CHIPS(NUM_CHIPS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_req(sel_req), .sel_idx(sel_idx), .desel_req(desel_req),
    .pm_suspend_req(pm_suspend_req), .pm_resume_req(pm_resume_req),
    .clk_req(clk_req), .clk_req_st(clk_req_st), .ce_op(ce_op),
    .sel_err(sel_err), .timing_init(timing_init), .busy(busy)
  );

  nand_cgcs_clkfsm #(.ALLOW_IDLE(ALLOW_IDLE)) u_clk (
    .clk(clk), .rst_n(rst_n),
    .req(clk_req), .req_st(clk_req_st),
    .state(st), .gate_en(clk_gate_en)
  );

  nand_cgcs_cereg u_ce (
    .clk(clk), .rst_n(rst_n), .op(ce_op), .ce_n(chip_en_n)
  );

  assign clk_state = st;

  // R5: chip enable is only asserted while the clock runs
  p_ce_needs_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_en_n) |-> clk_gate_en);

  // R6: a rejected select leaves chip enable alone
  p_err_keeps_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> $stable(chip_en_n));

  // R7: deselect releases chip enable at once
  p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_req && !busy && !pm_suspend_req && !pm_resume_req) |=> chip_en_n);

  // R8: power-down stops the clock and releases chip enable together
  p_pm_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_suspend_req && !busy) |=> (chip_en_n && clk_state == 2'd0 && !clk_gate_en));

  // R9: the reload pulse appears only with the clock running
  p_tinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timing_init |-> clk_gate_en);

endmodule

// File: tb/nand_cgcs_test.sv
module nand_cgcs_test;

  localparam int NCH = 4;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_req = 1'b0, desel_req = 1'b0, pm_suspend_req = 1'b0, pm_resume_req = 1'b0;
  logic [IW-1:0] sel_idx = '0;

  logic       gate [2];
  logic       cen  [2];
  logic [1:0] cst  [2];
  logic       err  [2];
  logic       tin  [2];
  logic       bsy  [2];

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  int  m_st [2];
  bit  m_ce [2];
  bit  m_sv [2];
  int  m_ph [2];
  bit  m_er [2];
  bit  m_ti [2];

  always #4 clk = ~clk;

  nand_cgcs #(.NUM_CHIPS(NCH), .IDX_W(IW), .ALLOW_IDLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_idx(sel_idx),
    .desel_req(desel_req), .pm_suspend_req(pm_suspend_req), .pm_resume_req(pm_resume_req),
    .clk_gate_en(gate[0]), .chip_en_n(cen[0]), .clk_state(cst[0]),
    .sel_err(err[0]), .timing_init(tin[0]), .busy(bsy[0])
  );

  nand_cgcs #(.NUM_CHIPS(NCH), .IDX_W(IW), .ALLOW_IDLE(1'b0)) uut_noidle (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_idx(sel_idx),
    .desel_req(desel_req), .pm_suspend_req(pm_suspend_req), .pm_resume_req(pm_resume_req),
    .clk_gate_en(gate[1]), .chip_en_n(cen[1]), .clk_state(cst[1]),
    .sel_err(err[1]), .timing_init(tin[1]), .busy(bsy[1])
  );

  task automatic check(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic int next_state(input int cur, input int req, input bit allow);
    if (req < 0) return cur;
    if (req == 2 && !allow) return cur;
    return req;
  endfunction

  task automatic model_tick(input int i, input bit allow);
    int req;
    req = -1;
    m_er[i] = 0;
    m_ti[i] = 0;
    case (m_ph[i])
      0: begin
        if (pm_suspend_req) begin
          m_sv[i] = m_ce[i]; m_ce[i] = 1; req = 0;
        end else if (pm_resume_req) begin
          req = 1; m_ti[i] = 1; m_ph[i] = 3;
        end else if (desel_req) begin
          m_ce[i] = 1; m_ph[i] = 2;
        end else if (sel_req) begin
          req = 1;
          if (int'(sel_idx) <= NCH) m_ph[i] = 1; else m_er[i] = 1;
        end
      end
      1: begin m_ce[i] = 0; m_ph[i] = 0; end
      2: begin req = 2; m_ph[i] = 0; end
      3: begin m_ce[i] = m_sv[i]; m_ph[i] = 4; end
      default: begin req = 2; m_ph[i] = 0; end
    endcase
    m_st[i] = next_state(m_st[i], req, allow);
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      check($sformatf("R2 state[%0d]", i), int'(cst[i]), m_st[i]);
      check($sformatf("R3 gate[%0d]", i), int'(gate[i]), (m_st[i] == 1) ? 1 : 0);
      check($sformatf("ce_n[%0d]", i), int'(cen[i]), int'(m_ce[i]));
      check($sformatf("R6 err[%0d]", i), int'(err[i]), int'(m_er[i]));
      check($sformatf("R9 tinit[%0d]", i), int'(tin[i]), int'(m_ti[i]));
      check($sformatf("R10 busy[%0d]", i), int'(bsy[i]), (m_ph[i] != 0) ? 1 : 0);
    end
  endtask

  task automatic step(input bit s, input int idx, input bit d, input bit ps, input bit pr);
    @(negedge clk);
    sel_req = s; sel_idx = IW'(idx); desel_req = d;
    pm_suspend_req = ps; pm_resume_req = pr;
    @(posedge clk);
    model_tick(0, 1'b1);
    model_tick(1, 1'b0);
    #2;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      m_st[i] = 0; m_ce[i] = 1; m_sv[i] = 1; m_ph[i] = 0; m_er[i] = 0; m_ti[i] = 0;
    end
    #20;
    tag = "R1";
    compare_all();
    @(negedge clk); rst_n = 1'b1;

    tag = "R5";
    step(1, 2, 0, 0, 0);
    idle(2);
    tag = "R5";
    step(1, NCH, 0, 0, 0);
    idle(2);
    tag = "R7";
    step(0, 0, 1, 0, 0);
    idle(2);
    tag = "R4";
    step(0, 0, 1, 0, 0);
    idle(2);
    tag = "R6";
    step(1, NCH + 1, 0, 0, 0);
    step(1, 7, 0, 0, 0);
    idle(1);
    tag = "R5";
    step(1, 0, 0, 0, 0);
    idle(1);
    tag = "R8";
    step(0, 0, 0, 1, 0);
    idle(1);
    tag = "R9";
    step(0, 0, 0, 0, 1);
    idle(3);
    tag = "R8";
    step(0, 0, 1, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0);
    tag = "R9";
    step(0, 0, 0, 0, 1);
    idle(3);
    tag = "R10";
    step(1, 1, 1, 1, 1);
    step(1, 1, 1, 0, 1);
    step(1, 1, 0, 0, 0);
    idle(2);
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    idle(2);
    tag = "R3";
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    idle(1);

    tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 18, $urandom_range(0, 7), (r >= 18 && r < 30),
           (r >= 30 && r < 36), (r >= 36 && r < 44));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule